// File: doc/BRIEF.md
# Desynchronized Pipeline Stage Strobe Selector

This block sits beside one pipeline register and decides what captures it. With the mode input low, the register strobe is the global clock, passed straight through. With the mode input high, the strobe comes from a local handshake path. An upstream request first waits out a programmable matched delay, counted in reference-clock cycles. That delay stands in for completion detection of the combinational logic in front of the register. The delayed request is then forwarded and also fires a strobe pulse. The pulse is stretched to a guaranteed minimum width and held until the downstream side acknowledges it.

One mode input is meant to be wired in common to every stage, so a whole pipeline switches between clocked and self-timed operation together. A delay-select code sets the matched delay for each request. The stage that closes the pipeline loop is built with a startup token. After reset it produces one strobe of its own, so the first handshake cycle can begin. Two observation outputs show which strobe source is selected and which delay code the last request used.

Top module: `desync_stage_clksel`

## Requirements
- R1: While `mode_async` is 0, `strobe` follows `clk` at all times, `req_dly` stays 0, and requests on `req_in` have no effect on `req_dly`.
- R2: While `rst` is high (sampled on a rising `clk` edge), `req_dly` and `obs_dly` are 0 afterwards, and `strobe` is 0 when `mode_async` is 1.
- R3: In desynchronized mode, when the stage is idle and a rising edge of `clk` first samples `req_in` high with delay code D on `dly_sel`, `req_dly` rises after exactly D+1 further rising edges and is 0 before that.
- R4: Once `req_dly` is high, it stays high while `req_in` is high. It drops after the first edge that samples `req_in` low, and only then can a new request be accepted.
- R5: The edge after `req_dly` rises, `strobe` goes high and stays high for at least `MIN_W` clock cycles (4 by default).
- R6: After the minimum width, `strobe` stays high until an edge samples `ack_in` high, and falls after that edge.
- R7: With `ENABLE_TOKEN` = 1, the first rising edge after reset release that samples `mode_async` high starts exactly one strobe pulse without any request. No further token is produced until the next reset, even if the mode is toggled.
- R8: `obs_src` equals `mode_async` (0 = global clock, 1 = handshake strobe). `obs_dly` holds the delay code captured when the most recent request was accepted.
- R9: Changes of `dly_sel` while a delay is being counted do not alter that delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock, also the reference for delay and width counting |
| rst | input | 1 | Synchronous active-high reset |
| mode_async | input | 1 | 0 = global clock strobe, 1 = handshake strobe |
| dly_sel | input | DLY_W | Matched-delay code in reference cycles |
| req_in | input | 1 | Request from the upstream handshake controller |
| ack_in | input | 1 | Acknowledge from the downstream side for the current strobe |
| strobe | output | 1 | Capture strobe for the pipeline register |
| req_dly | output | 1 | Request after the matched delay |
| obs_src | output | 1 | Selected strobe source |
| obs_dly | output | DLY_W | Delay code of the last accepted request |

## Verification
Requests are sent with the smallest code, a middle code and the largest code. Missing the zero case hides an off-by-one in the countdown, and the largest case exposes wrap-around. A code change in the middle of a count checks that the captured code is the one used rather than the live input. Two acknowledge patterns are used: acknowledge held high, which separates the minimum-width guard from the acknowledge hold, and acknowledge arriving late, which checks that the hold lasts beyond the minimum. Stretches in clocked mode with `req_in` toggling, and returns to handshake mode after them, show that the mux follows the clock and that the startup token fires once only.

// File: rtl/desync_pkg.sv
package desync_pkg;

    // matched-delay sequencing
    typedef enum logic [1:0] {
        DL_IDLE  = 2'd0,
        DL_COUNT = 2'd1,
        DL_HOLD  = 2'd2
    } dly_state_e;

    // strobe source shown on the observation output
    typedef enum logic {
        SRC_CLK = 1'b0,
        SRC_HS  = 1'b1
    } strobe_src_e;

    // outputs of the matched-delay element
    typedef struct packed {
        logic req;   // delayed request level
        logic fire;  // one-cycle pulse in the cycle the request is forwarded
    } dly_out_t;

    // width of the minimum-width down-counter
    function automatic int width_cnt_bits(input int min_w);
        return (min_w > 1) ? $clog2(min_w) : 1;
    endfunction

endpackage

// File: rtl/ds_match_delay.sv
module ds_match_delay
    import desync_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             req_in,
    input  logic [DLY_W-1:0] dly_sel,
    output dly_out_t         out,
    output logic [DLY_W-1:0] code_q
);

    dly_state_e       state;
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= DL_IDLE;
            cnt      <= '0;
            out      <= '0;
            code_q   <= '0;
        end else if (!en) begin
            state    <= DL_IDLE;
            cnt      <= '0;
            out      <= '0;
        end else begin
            out.fire <= 1'b0;
            unique case (state)
                DL_IDLE: begin
                    if (req_in) begin
                        state  <= DL_COUNT;
                        cnt    <= dly_sel;
                        code_q <= dly_sel;
                    end
                end
                DL_COUNT: begin
                    if (cnt == '0) begin
                        state    <= DL_HOLD;
                        out.req  <= 1'b1;
                        out.fire <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                DL_HOLD: begin
                    if (!req_in) begin
                        state   <= DL_IDLE;
                        out.req <= 1'b0;
                    end
                end
                default: state <= DL_IDLE;
            endcase
        end
    end

    // R3: a forwarded request is always preceded by an upstream request
    a_r3_no_spurious_req: assert property (@(posedge clk) disable iff (rst)
        $rose(out.req) |-> $past(state) == DL_COUNT);

    // R4: a withdrawn upstream request removes the delayed request next cycle
    a_r4_release: assert property (@(posedge clk) disable iff (rst)
        (out.req && !req_in) |=> !out.req);

endmodule

// File: rtl/ds_strobe_stretch.sv
module ds_strobe_stretch
    import desync_pkg::*;
#(
    parameter int MIN_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic trig,
    input  logic ack_in,
    output logic stb
);

    localparam int WC_W = width_cnt_bits(MIN_W);

    logic [WC_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            stb  <= 1'b0;
            wcnt <= '0;
        end else if (stb) begin
            if (wcnt != '0) begin
                wcnt <= wcnt - 1'b1;
            end else if (ack_in) begin
                stb <= 1'b0;
            end
        end else if (trig) begin
            stb  <= 1'b1;
            wcnt <= WC_W'(MIN_W - 1);
        end
    end

    // observation counter for the width property
    logic [7:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst || !stb) hi_cnt <= '0;
        else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
    end

    // R5: every pulse ended by normal operation lasted at least MIN_W cycles
    a_r5_min_width: assert property (@(posedge clk) disable iff (rst)
        ($fell(stb) && !$past(rst) && $past(en)) |-> (hi_cnt >= 8'(MIN_W)));

    // R6: without acknowledge the strobe is never released
    a_r6_hold_for_ack: assert property (@(posedge clk) disable iff (rst)
        (stb && !ack_in && en) |=> stb);

endmodule

// File: rtl/ds_start_token.sv
module ds_start_token (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tok
);

    logic done;

    always_comb tok = en && !done;

    always_ff @(posedge clk) begin
        if (rst)      done <= 1'b0;
        else if (tok) done <= 1'b1;
    end

    // R7: the token is a single-cycle event
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
        tok |=> !tok);

    // R7: once spent, the token only comes back through reset
    a_r7_no_rearm: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> $past(rst));

endmodule

// File: rtl/desync_stage_clksel.sv
module desync_stage_clksel
    import desync_pkg::*;
#(
    parameter int DLY_W        = 4,
    parameter int MIN_W        = 4,
    parameter bit ENABLE_TOKEN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_async,
    input  logic [DLY_W-1:0] dly_sel,
    input  logic             req_in,
    input  logic             ack_in,
    output logic             strobe,
    output logic             req_dly,
    output logic             obs_src,
    output logic [DLY_W-1:0] obs_dly
);

    dly_out_t    dly_o;
    logic        tok;
    logic        hs_stb;
    strobe_src_e src;

    ds_match_delay #(.DLY_W(DLY_W)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .en      (mode_async),
        .req_in  (req_in),
        .dly_sel (dly_sel),
        .out     (dly_o),
        .code_q  (obs_dly)
    );

    generate
        if (ENABLE_TOKEN) begin : g_token
            ds_start_token u_token (
                .clk (clk),
                .rst (rst),
                .en  (mode_async),
                .tok (tok)
            );
        end else begin : g_no_token
            assign tok = 1'b0;
        end
    endgenerate

    ds_strobe_stretch #(.MIN_W(MIN_W)) u_stretch (
        .clk    (clk),
        .rst    (rst),
        .en     (mode_async),
        .trig   (dly_o.fire | tok),
        .ack_in (ack_in),
        .stb    (hs_stb)
    );

    always_comb begin
        src     = mode_async ? SRC_HS : SRC_CLK;
        strobe  = (src == SRC_HS) ? hs_stb : clk;
        req_dly = dly_o.req;
        obs_src = src;
    end

    // R1: in clocked mode no delayed request is ever presented
    a_r1_quiet_sync: assert property (@(posedge clk) disable iff (rst)
        !mode_async |=> (!req_dly || mode_async));

endmodule

// File: tb/tb_desync_stage_clksel.sv
module tb_desync_stage_clksel;

    localparam int CLK_PERIOD = 10;
    localparam int DLY_W      = 4;
    localparam int MIN_W      = 4;

    logic             clk = 1'b0;
    logic             rst, mode_async, req_in, ack_in;
    logic [DLY_W-1:0] dly_sel;
    logic             strobe, req_dly, obs_src;
    logic [DLY_W-1:0] obs_dly;

    desync_stage_clksel #(.DLY_W(DLY_W), .MIN_W(MIN_W), .ENABLE_TOKEN(1'b1)) dut (
        .clk(clk), .rst(rst), .mode_async(mode_async), .dly_sel(dly_sel),
        .req_in(req_in), .ack_in(ack_in), .strobe(strobe), .req_dly(req_dly),
        .obs_src(obs_src), .obs_dly(obs_dly)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    string tag = "R2";
    bit    finished = 0;

    // behavioural reference: event times, not state machines
    int edge_no = 0;
    int phase = 0;          // 0 idle, 1 waiting, 2 forwarded
    int fire_at = 0;
    bit m_rdy = 0, m_pend = 0, m_stb = 0, tok_used = 0;
    int m_age = 0;
    int m_code = 0;

    always @(posedge clk) begin
        bit trig;
        edge_no++;
        if (rst) begin
            phase = 0; m_rdy = 0; m_pend = 0; m_stb = 0; tok_used = 0; m_code = 0;
        end else if (!mode_async) begin
            phase = 0; m_rdy = 0; m_pend = 0; m_stb = 0;
        end else begin
            trig = m_pend;
            m_pend = 0;
            if (!tok_used) begin trig = 1; tok_used = 1; end
            if (phase == 0 && req_in) begin
                phase = 1; fire_at = edge_no + int'(dly_sel) + 1; m_code = int'(dly_sel);
            end else if (phase == 1 && edge_no == fire_at) begin
                phase = 2; m_rdy = 1; m_pend = 1;
            end else if (phase == 2 && !req_in) begin
                phase = 0; m_rdy = 0;
            end
            if (m_stb) begin
                m_age++;
                if (m_age >= MIN_W && ack_in) m_stb = 0;
            end else if (trig) begin
                m_stb = 1; m_age = 0;
            end
        end
    end

    task automatic cmp(string what, string rq, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s at edge %0d: actual %0d expected %0d", rq, what, edge_no, act, exp);
        end
    endtask

    // low-phase comparison of every output
    always @(negedge clk) if (!finished) begin
        cmp("strobe", tag, int'(strobe), mode_async ? int'(m_stb) : 0);
        cmp("req_dly", "R3/R4", int'(req_dly), int'(m_rdy));
        cmp("obs_src", "R8", int'(obs_src), int'(mode_async));
        cmp("obs_dly", "R8", int'(obs_dly), m_code);
    end

    // high-phase comparison of the strobe (R1 pass-through)
    always @(posedge clk) if (!finished) begin
        #(CLK_PERIOD/4);
        cmp("strobe_hi", tag, int'(strobe), mode_async ? int'(m_stb) : 1);
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    // one four-phase request with code d; code may change mid-count (R9)
    task automatic request(int d, int alt_code);
        dly_sel = DLY_W'(d);
        req_in  = 1'b1;
        cycles(1);
        if (alt_code >= 0) dly_sel = DLY_W'(alt_code);
        for (int i = 0; i < 40 && !req_dly; i++) cycles(1);
        cycles(2);
        req_in = 1'b0;
        cycles(MIN_W + 3);
    endtask

    initial begin
        rst = 1; mode_async = 1; req_in = 0; ack_in = 1; dly_sel = '0;
        tag = "R2";               // reset state
        cycles(4);
        tag = "R7";               // startup token on release
        rst = 0;
        cycles(MIN_W + 4);
        tag = "R3";               // delay codes: zero, middle, largest
        request(0, -1);
        request(5, -1);
        request(15, -1);
        tag = "R5";               // back-to-back requests keep minimum width
        request(1, -1);
        request(2, -1);
        tag = "R9";               // code change mid-count ignored
        request(6, 1);
        request(2, 15);
        tag = "R6";               // late acknowledge stretches strobe
        ack_in = 0;
        dly_sel = 4'd3; req_in = 1;
        cycles(MIN_W + 10);
        req_in = 0;
        cycles(3);
        ack_in = 1;
        cycles(4);
        tag = "R1";               // clocked mode with request activity
        mode_async = 0;
        for (int i = 0; i < 6; i++) begin
            req_in = ~req_in;
            cycles(3);
        end
        req_in = 0;
        tag = "R7";               // return to handshake: no second token
        mode_async = 1;
        cycles(MIN_W + 4);
        tag = "R3";
        request(4, -1);
        tag = "R1";
        mode_async = 0;
        cycles(5);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: actual running expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule